// File: doc/BRIEF.md
# Spindle Lock Monitor

This block decides whether a disc spindle is turning at a usable speed. Each clock it compares a 5-bit speed code from the measurement logic against a lock window held in one packed 8-bit register. It reports "stable" when the code lies inside that window while spin-up is enabled. The nominal playback code is 16 (10000b). The lower bound is taken from the low five bits of the register. The upper bound is 16 plus the register's top three bits, so the window can be asymmetric about the nominal speed.

While spin-up is enabled and the speed is outside the window, a prescaled time base (one tick per `TICK_CYCLES` clocks, nominally 8 ms) advances a miss counter. When the number of ticks exceeds a programmable mask time, the block raises a sticky restart request to the servo controller. Any return to the window restarts the timing. The block also presents a readback form of the speed that is zero while idle and capped at the nominal code.

Both registers are loaded through a simple write port.

Top module: `spindle_lock_monitor`

## Requirements
- R1: After reset the window register holds EFh. Its bits [4:0] give the inclusive lower speed bound, 15 (01111b) by default.
- R2: The inclusive upper bound equals 16 plus window register bits [7:5], so it lies between 16 and 23. The default is 23 (10111b).
- R3: `stable_o` is registered. One clock after the inputs, it is 1 exactly when `spin_en_i` is 1 and the lower bound <= `speed_i` <= the upper bound.
- R4: When `wr_en_i` is 1, `wr_data_i` is written on the next clock edge. `wr_sel_i`=0 selects the window register and `wr_sel_i`=1 selects the mask register. The mask register resets to 40h.
- R5: The out-of-window timing advances only while `spin_en_i` is 1. A disabled monitor never requests a restart, however long the speed is outside the window.
- R6: With mask value M, `restart_o` rises on the clock edge that completes (M+1)*`TICK_CYCLES` consecutive enabled cycles with the speed outside the window. It does not rise one edge earlier. This holds for M=0 as well.
- R7: Any cycle in which the speed is inside the window resets the time base and the miss count. A new excursion then needs the full (M+1)*`TICK_CYCLES` cycles again.
- R8: Once set, `restart_o` stays 1 while `spin_en_i` stays 1, including after the speed returns to the window. It clears on reset or one edge after `spin_en_i` goes to 0.
- R9: `speed_rd_o` is registered. One clock after the inputs it is 0 while `spin_en_i` is 0. Otherwise it is min(`speed_i`, 16), zero-extended to 8 bits (format 000xxxxx).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spin_en_i | input | 1 | Spin-up enable; gates timing, stable flag and readback |
| speed_i | input | 5 | Measured spindle speed code |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 window register, 1 mask register |
| wr_data_i | input | 8 | Register write data |
| stable_o | output | 1 | Speed inside lock window |
| restart_o | output | 1 | Sticky servo restart request |
| speed_rd_o | output | 8 | Saturated speed readback |

## Verification
The window comparison is swept over every combination of the 3-bit upper field, the 5-bit lower field and all 32 speed codes. This sweep separates off-by-one errors at either bound and confusion between the two fields. The mask timer is driven with several mask values, including zero and the reset default. The output is sampled one edge before and exactly at the predicted rise, which distinguishes an M versus M+1 tick count and any prescaler phase error. A short dip into the window partway through an excursion shows whether the timing really restarts. Disabled spin-up and a return to the window show whether the request is gated and sticky as required. The readback is swept across all speeds with the enable on and off, which exposes the saturation point.

// File: rtl/spdmon_pkg.sv
package spdmon_pkg;
  typedef enum logic {
    SEL_WINDOW = 1'b0,
    SEL_MASK   = 1'b1
  } wr_target_e;
endpackage

// File: rtl/spdmon_regs.sv
module spdmon_regs
  import spdmon_pkg::*;
#(
  parameter int              REG_W     = 8,
  parameter logic [REG_W-1:0] WIN_INIT  = 8'hEF,
  parameter logic [REG_W-1:0] MASK_INIT = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] win_o,
  output logic [REG_W-1:0] mask_o
);
  wr_target_e target;
  assign target = wr_target_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o  <= WIN_INIT;
      mask_o <= MASK_INIT;
    end else if (wr_en) begin
      if (target == SEL_WINDOW) win_o  <= wr_data;
      else                      mask_o <= wr_data;
    end
  end

  // R4: a write lands in the selected register on the next edge
  p_win_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (win_o == $past(wr_data)));
  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mask_o == $past(wr_data)));
endmodule

// File: rtl/spdmon_window.sv
module spdmon_window #(
  parameter int SPD_W = 5,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SPD_W-1:0] speed,
  input  logic [REG_W-1:0] win,
  output logic             in_win_o,
  output logic             stable_o,
  output logic [REG_W-1:0] speed_rd_o
);
  localparam int UW      = SPD_W + 1;
  localparam int NOMINAL = 1 << (SPD_W - 1);
  typedef logic [UW-1:0] ext_t;

  function automatic ext_t lower_of(input logic [REG_W-1:0] w);
    return ext_t'(w[SPD_W-1:0]);
  endfunction

  function automatic ext_t upper_of(input logic [REG_W-1:0] w);
    return ext_t'(NOMINAL) + ext_t'(w[REG_W-1:SPD_W]);
  endfunction

  function automatic logic [REG_W-1:0] cap_speed(input logic [SPD_W-1:0] s);
    if (ext_t'(s) > ext_t'(NOMINAL)) return REG_W'(NOMINAL);
    return REG_W'(s);
  endfunction

  ext_t spd_ext;
  assign spd_ext  = ext_t'(speed);
  assign in_win_o = (spd_ext >= lower_of(win)) && (spd_ext <= upper_of(win));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_o   <= 1'b0;
      speed_rd_o <= '0;
    end else begin
      stable_o   <= en && in_win_o;
      speed_rd_o <= en ? cap_speed(speed) : '0;
    end
  end

  // R3: idle monitor never reports lock
  p_stable_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stable_o);
  // R9: readback zero when idle, never above nominal
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (speed_rd_o == '0));
  p_rd_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    speed_rd_o <= REG_W'(NOMINAL));
endmodule

// File: rtl/spdmon_timer.sv
module spdmon_timer #(
  parameter int REG_W       = 8,
  parameter int TICK_CYCLES = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_win,
  input  logic [REG_W-1:0] mask,
  output logic             tick_o,
  output logic             restart_o
);
  localparam int PRE_W = $clog2(TICK_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [REG_W-1:0] miss_q;
  logic             expire;

  assign tick_o = en && !in_win && (pre_q == PRE_LAST);
  assign expire = tick_o && (miss_q >= mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      miss_q    <= '0;
      restart_o <= 1'b0;
    end else if (!en) begin
      pre_q     <= '0;
      miss_q    <= '0;
      restart_o <= 1'b0;
    end else if (in_win) begin
      pre_q  <= '0;
      miss_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (expire)      restart_o <= 1'b1;
      else if (tick_o) miss_q    <= miss_q + 1'b1;
    end
  end

  // R6: the request can only rise on a time-base tick
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_o) |-> $past(tick_o));
  // R7: a cycle in the window clears the miss count
  p_reentry_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_win) |=> (miss_q == '0 && pre_q == '0));
  // R8: sticky while enabled, cleared when disabled
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart_o) |=> restart_o);
  p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !restart_o);
endmodule

// File: rtl/spindle_lock_monitor.sv
module spindle_lock_monitor #(
  parameter int              SPD_W       = 5,
  parameter int              REG_W       = 8,
  parameter int              TICK_CYCLES = 1_000_000,
  parameter logic [REG_W-1:0] WIN_INIT    = 8'hEF,
  parameter logic [REG_W-1:0] MASK_INIT   = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spin_en_i,
  input  logic [SPD_W-1:0] speed_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             stable_o,
  output logic             restart_o,
  output logic [REG_W-1:0] speed_rd_o
);
  logic [REG_W-1:0] win_q;
  logic [REG_W-1:0] mask_q;
  logic             in_win;
  logic             tick;

  spdmon_regs #(
    .REG_W(REG_W), .WIN_INIT(WIN_INIT), .MASK_INIT(MASK_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
    .wr_data(wr_data_i), .win_o(win_q), .mask_o(mask_q)
  );

  spdmon_window #(.SPD_W(SPD_W), .REG_W(REG_W)) u_window (
    .clk(clk), .rst_n(rst_n), .en(spin_en_i), .speed(speed_i), .win(win_q),
    .in_win_o(in_win), .stable_o(stable_o), .speed_rd_o(speed_rd_o)
  );

  spdmon_timer #(.REG_W(REG_W), .TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(spin_en_i), .in_win(in_win), .mask(mask_q),
    .tick_o(tick), .restart_o(restart_o)
  );

  // R5: no tick, hence no restart progress, while disabled
  p_no_tick_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !spin_en_i |-> !tick);
endmodule

// File: tb/test_spindle_lock_monitor.sv
`timescale 1ns/1ps
module test_spindle_lock_monitor;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spin_en_i = 1'b0;
  logic [4:0] speed_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       stable_o, restart_o;
  logic [7:0] speed_rd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spindle_lock_monitor #(.TICK_CYCLES(P)) i_spindle_lock_monitor (
    .clk(clk), .rst_n(rst_n), .spin_en_i(spin_en_i), .speed_i(speed_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .stable_o(stable_o), .restart_o(restart_o), .speed_rd_o(speed_rd_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    edges(1);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_run();
    spin_en_i = 1'b0; edges(1);
  endtask

  // Check restart timing for mask m: window EFh, out code 0
  task automatic timer_case(input int m);
    int need;
    need = (m + 1) * P;
    clear_run();
    wr(1'b1, 8'(m));
    wr(1'b0, 8'hEF);
    speed_i = 5'd16; spin_en_i = 1'b1; edges(2);
    speed_i = 5'd0;
    edges(need - 1);
    check("R6 no early restart", restart_o, 0);
    edges(1);
    check("R6 restart on time", restart_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset stable", stable_o, 0);
    check("R8 reset restart", restart_o, 0);
    check("R9 reset readback", speed_rd_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2 default window bounds 15..23
    spin_en_i = 1'b1;
    for (int s = 13; s <= 25; s++) begin
      speed_i = 5'(s); edges(1);
      check("R1 R2 default window", stable_o, (s >= 15 && s <= 23) ? 1 : 0);
    end

    // R4 default mask 40h: restart after 65*P out-of-window cycles
    clear_run();
    spin_en_i = 1'b1; speed_i = 5'd16; edges(2);
    speed_i = 5'd14;
    edges(65 * P - 1);
    check("R4 default mask early", restart_o, 0);
    edges(1);
    check("R4 default mask rise", restart_o, 1);
    clear_run();

    // R5 disabled: no restart however long outside
    speed_i = 5'd0; edges(20 * P);
    check("R5 idle never restarts", restart_o, 0);

    // R6 timing across masks
    timer_case(0);
    timer_case(1);
    timer_case(3);

    // R8 sticky through window return, cleared by disable
    speed_i = 5'd16; edges(5);
    check("R8 sticky in window", restart_o, 1);
    spin_en_i = 1'b0; edges(1);
    check("R8 cleared by disable", restart_o, 0);

    // R7 re-entry restarts timing (mask 1 -> 2*P cycles)
    wr(1'b1, 8'd1);
    spin_en_i = 1'b1; speed_i = 5'd16; edges(2);
    speed_i = 5'd0;  edges(2 * P - 1);
    speed_i = 5'd16; edges(1);
    speed_i = 5'd0;  edges(2 * P - 1);
    check("R7 no restart after re-entry", restart_o, 0);
    edges(1);
    check("R7 full window then restart", restart_o, 1);

    // R4/R1/R2/R3 exhaustive window sweep
    for (int hi = 0; hi < 8; hi++) begin
      for (int lo = 0; lo < 32; lo++) begin
        wr(1'b0, 8'((hi << 5) | lo));
        for (int s = 0; s < 32; s++) begin
          speed_i = 5'(s); edges(1);
          check("R3 window sweep", stable_o,
                (s >= lo && s <= 16 + hi) ? 1 : 0);
        end
      end
    end

    // R3 disabled never stable; R9 readback sweep
    wr(1'b0, 8'hEF);
    for (int s = 0; s < 32; s++) begin
      spin_en_i = 1'b1; speed_i = 5'(s); edges(1);
      check("R9 readback enabled", speed_rd_o, (s > 16) ? 16 : s);
      spin_en_i = 1'b0; edges(1);
      check("R9 readback idle", speed_rd_o, 0);
      check("R3 idle not stable", stable_o, 0);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule